// File: doc/BRIEF.md
# Hall-Edge Tachometer Pulse Converter

This block turns rotor position changes into a tachometer pulse train. It watches the three Hall sensor bits and passes them through a synchronizer chain whose depth is a parameter. Any change of the synchronized three-bit code starts one positive pulse. The pulse lasts a programmed number of clock cycles. Because every pulse has the same width, the pulse rate follows rotor speed, and the average level of the output is directly proportional to speed.

The width setting is a count of system clock cycles. It takes the place of an external timing network. A typical choice is a count equal to about 105 µs, anywhere in a 95 to 115 µs window. The analog integration of the pulse train into a speed error is done outside the block. An edge strobe can be built in with a parameter. It marks each detected code change for one cycle.

Top module: `tach_pulse_conv`

## Requirements
- R1: While reset is low, and after it is released, `tach_out` and `edge_stb` are low. Reset captures the present sensor code as the reference, so a steady non-zero code gives no pulse after release.
- R2: A change in any bit or bits of `hall_in` starts a pulse. `tach_out` first reads high after the (SYNC_STAGES+1)-th rising edge, counting the edge that first samples the new code as edge 1.
- R3: A pulse stays high for exactly N cycles, where N is the `width_set` value sampled in the start cycle. Changing `width_set` during a pulse has no effect on that pulse.
- R4: A code change while a pulse is high restarts the width count with the current `width_set`. The output does not go low in between.
- R5: A code change with `width_set` = 0 produces no pulse. If a pulse is active at that moment, the change ends it at once.
- R6: With STROBE_EN = 1, `edge_stb` is high for one cycle per detected code change, whatever the width. It is high in the same cycle in which the pulse goes high.
- R7: While the synchronized code stays stable, no new pulse starts.
- R8: K code changes spaced further apart than the width N give K separate pulses and K·N high cycles in total, so the duty follows the change rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hall_in | input | 3 | Raw Hall sensor bits |
| width_set | input | WIDTH_W | Pulse width in clock cycles; 0 suppresses the pulse |
| tach_out | output | 1 | Fixed-width tachometer pulse |
| edge_stb | output | 1 | One-cycle strobe per code change (tied low when STROBE_EN = 0) |

## Verification
The bench targets a non-zero code held through reset. A design that compared against a cleared reference would emit a phantom pulse there.

It raises `width_set` in the middle of a pulse. A design that counted against the live setting would stretch that pulse.

It also sends a second change into a running pulse and a zero-width change into a running pulse. A design that ignored retriggers would give a short total. One that did not cancel would let the old pulse run on.

Random code steps, widths and gaps are compared cycle by cycle against a bench model. This exposes off-by-one latency and width errors.

// File: rtl/tach_pkg.sv
package tach_pkg;
   localparam int HALL_W = 3;
   typedef logic [HALL_W-1:0] hall_code_t;
endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
   parameter int STAGES = 2,
   parameter int DW     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [DW-1:0] st_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st_q[i] <= din;
            end else begin
               st_q[0] <= din;
               for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
            end
         end
         assign dout = st_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tach_edge_det.sv
module tach_edge_det
   import tach_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  hall_code_t raw_code,
   input  hall_code_t sync_code,
   output logic       code_chg
);
   hall_code_t ref_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ref_q <= raw_code;
      else        ref_q <= sync_code;
   end

   assign code_chg = (sync_code != ref_q);
endmodule

// File: rtl/tach_pulse_timer.sv
module tach_pulse_timer #(
   parameter int WIDTH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH_W-1:0] width,
   output logic               pulse_q
);
   logic [WIDTH_W-1:0] cnt_q, cnt_nxt;

   always_comb begin
      cnt_nxt = cnt_q;
      if (start)              cnt_nxt = width;
      else if (cnt_q != '0)   cnt_nxt = cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_nxt;
         pulse_q <= (cnt_nxt != '0);
      end
   end
endmodule

// File: rtl/tach_pulse_conv.sv
module tach_pulse_conv
   import tach_pkg::*;
#(
   parameter int WIDTH_W     = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit STROBE_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         hall_in,
   input  logic [WIDTH_W-1:0] width_set,
   output logic               tach_out,
   output logic               edge_stb
);
   generate
      if (WIDTH_W < 1 || WIDTH_W > 32) begin : g_bad_width
         $error("tach_pulse_conv: WIDTH_W must be 1..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("tach_pulse_conv: SYNC_STAGES must be 0..4");
      end
   endgenerate

   hall_code_t sync_code;
   logic       code_chg;

   tach_sync #(.STAGES(SYNC_STAGES), .DW(HALL_W)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (hall_in),
      .dout (sync_code)
   );

   tach_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_code (hall_in),
      .sync_code(sync_code),
      .code_chg (code_chg)
   );

   tach_pulse_timer #(.WIDTH_W(WIDTH_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (code_chg),
      .width  (width_set),
      .pulse_q(tach_out)
   );

   generate
      if (STROBE_EN) begin : g_stb
         logic stb_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stb_q <= 1'b0;
            else        stb_q <= code_chg;
         end
         assign edge_stb = stb_q;
      end else begin : g_no_stb
         assign edge_stb = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tach_pulse_conv_chk.sv
module tach_pulse_conv_chk #(
   parameter int WIDTH_W   = 8,
   parameter bit STROBE_EN = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               code_chg,
   input logic [WIDTH_W-1:0] width_set,
   input logic               tach_out,
   input logic               edge_stb
);
   logic [WIDTH_W:0]   run_q;
   logic [WIDTH_W-1:0] lim_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         lim_q <= '0;
      end else if (code_chg) begin
         run_q <= (width_set != '0) ? {{WIDTH_W{1'b0}}, 1'b1} : '0;
         lim_q <= width_set;
      end else if (tach_out) begin
         run_q <= run_q + 1'b1;
      end
   end

   AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (code_chg && width_set != '0) |=> tach_out); // R2
   AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (code_chg && width_set == '0) |=> !tach_out); // R5
   AST_NO_SELF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tach_out) |-> $past(code_chg)); // R7
   AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tach_out |-> (run_q != '0 && run_q <= {1'b0, lim_q})); // R3
   AST_WIDTH_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tach_out) && !$past(code_chg)) |-> (run_q == {1'b0, lim_q} + 1'b1)); // R3

   generate
      if (STROBE_EN) begin : g_stb_chk
         AST_STB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            code_chg |=> edge_stb); // R6
         AST_STB_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
            edge_stb |-> $past(code_chg)); // R6
      end
   endgenerate
endmodule

bind tach_pulse_conv tach_pulse_conv_chk #(.WIDTH_W(WIDTH_W), .STROBE_EN(STROBE_EN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .code_chg (code_chg),
   .width_set(width_set),
   .tach_out (tach_out),
   .edge_stb (edge_stb)
);

// File: tb/tach_pulse_conv_test.sv
module tach_pulse_conv_test;
   localparam int WW   = 8;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    hall_in = 3'b101;
   logic [WW-1:0] width_set = '0;
   logic          tach_out, edge_stb;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   tach_pulse_conv #(.WIDTH_W(WW), .SYNC_STAGES(SYNC), .STROBE_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .width_set(width_set),
      .tach_out(tach_out), .edge_stb(edge_stb));

   always #4 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // cycle model built from the requirements
   logic [2:0]    m_sync [SYNC];
   logic [2:0]    m_ref;
   int            m_cnt;
   bit            m_tach, m_stb, m_chg;

   function automatic int next_count(bit chg, int cur, int w);
      if (chg) return w;
      return (cur > 0) ? cur - 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < SYNC; k++) m_sync[k] = hall_in;
         m_ref = hall_in; m_cnt = 0; m_tach = 0; m_stb = 0;
      end else begin
         m_chg  = (m_sync[SYNC-1] != m_ref);
         m_cnt  = next_count(m_chg, m_cnt, int'(width_set));
         m_tach = (m_cnt != 0);
         m_stb  = m_chg;
         m_ref  = m_sync[SYNC-1];
         for (int k = SYNC-1; k > 0; k--) m_sync[k] = m_sync[k-1];
         m_sync[0] = hall_in;
      end
      #2;
      if (!done) begin
         chk("R3 tach model", int'(tach_out), int'(m_tach));
         chk("R6 strobe model", int'(edge_stb), int'(m_stb));
      end
   end

   int hi, stb, first;

   task automatic drive(input logic [2:0] code, input int w);
      @(negedge clk);
      hall_in = code;
      width_set = WW'(w);
   endtask

   task automatic measure(input int n);
      for (int i = 1; i <= n; i++) begin
         @(posedge clk); #2;
         if (tach_out) begin
            hi++;
            if (first == 0) first = i;
         end
         if (edge_stb) stb++;
      end
   endtask

   task automatic clr();
      hi = 0; stb = 0; first = 0;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [2:0] cur;
      repeat (5) @(posedge clk);
      #2;
      chk("R1 tach in reset", int'(tach_out), 0);
      chk("R1 strobe in reset", int'(edge_stb), 0);
      @(negedge clk); rst_n = 1'b1; width_set = 8'd5;
      clr(); measure(20);
      chk("R1 no pulse after reset", hi, 0);
      chk("R7 stable code quiet", stb, 0);

      // single-bit change, width 5
      drive(3'b100, 5); clr(); measure(20);
      chk("R2 latency", first, SYNC + 1);
      chk("R3 width 5", hi, 5);
      chk("R6 one strobe", stb, 1);

      // multi-bit change, width 1
      drive(3'b011, 1); clr(); measure(12);
      chk("R2 multi-bit change", first, SYNC + 1);
      chk("R3 width 1", hi, 1);

      // width raised mid-pulse
      drive(3'b010, 4); clr(); measure(4);
      @(negedge clk); width_set = 8'd9; measure(16);
      chk("R3 width held", hi, 4);

      // restart while high
      drive(3'b110, 6); clr(); measure(3);
      drive(3'b111, 6); measure(20);
      chk("R4 restart total", hi, 9);
      chk("R4 two strobes", stb, 2);

      // zero width
      drive(3'b001, 0); clr(); measure(12);
      chk("R5 zero width", hi, 0);
      chk("R6 strobe at zero width", stb, 1);

      // zero width cancels running pulse
      drive(3'b000, 8); clr(); measure(4);
      drive(3'b100, 0); measure(16);
      chk("R5 cancel", hi, 4);

      // rate proportional
      cur = 3'b100; clr();
      for (int j = 0; j < 10; j++) begin
         cur = cur ^ 3'b010;
         drive(cur, 4); measure(12);
      end
      chk("R8 high cycles", hi, 40);
      chk("R8 pulse count", stb, 10);

      // random mix, checked by the cycle model
      void'($urandom(32'd2718));
      for (int j = 0; j < 250; j++) begin
         logic [2:0] msk;
         msk = 3'($urandom_range(1, 7));
         cur = cur ^ msk;
         drive(cur, int'($urandom_range(0, 12)));
         repeat ($urandom_range(0, 15)) @(posedge clk);
      end
      repeat (30) @(posedge clk);
      #3;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule